// File: doc/BRIEF.md
# Calendar Timer Interrupt Controller

This block turns the events of a calendar timer into sticky status flags and a single interrupt request. The timer runs in one of two modes. In calendar mode, eight periodic sources are merged into one shared periodic flag: two sub-second ticks, plus one strobe for each update of the seconds, minutes, hours, day, month and year fields. An alarm comparator also checks a chosen subset of the minute, hour and weekday fields against the running time and sets an alarm flag. In counter mode, overflow and compare-match strobes set their own flags.

Software clears a flag by writing 0 to it, which is modelled here as a one-cycle clear pulse per flag. Events are accepted only while the run control is 1, and only from the sources that belong to the current mode. The request line is the registered OR of every flag whose enable is set and whose source belongs to the current mode. The time counters, the prescalers and the register bus sit outside this block.

Top module: `caltmr_irq_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all four flags and `irq_o` are 0.
- R2: In calendar mode with `run_i`=1, a strobe on `per_evt_i[k]` while `per_en_i[k]`=1 sets `per_flag_o` one clock later. The bit order is: 0 for quarter second, 1 for half second, 2 for second, 3 for minute, 4 for hour, 5 for day, 6 for month, 7 for year.
- R3: A periodic strobe whose enable bit is 0 does not set `per_flag_o`.
- R4: The alarm compares only the fields selected in `alm_fld_en_i`: bit 0 selects minute, bit 1 selects hour, bit 2 selects weekday. In calendar mode while running, the cycle in which the selected fields go from not matching to matching sets `alm_flag_o` one clock later, whatever the value of `alm_irq_en_i`.
- R5: When `alm_fld_en_i` is 0, the alarm never matches and `alm_flag_o` is never set.
- R6: In counter mode with `run_i`=1, `ovf_i` sets `ovf_flag_o` and `cmp_i` sets `cmp_flag_o`, each one clock later.
- R7: Calendar sources (periodic and alarm) have no effect in counter mode (`mode_cnt_i`=1). Counter sources have no effect in calendar mode.
- R8: While `run_i`=0, no source sets any flag.
- R9: A clear pulse on `flag_clr_i[k]` clears the flag one clock later. The bit order is: 0 for periodic, 1 for alarm, 2 for overflow, 3 for compare. An event in the same cycle as the clear takes priority, and the flag stays 1.
- R10: A set alarm, overflow or compare flag drives `irq_o` only when its own enable is 1. A set periodic flag drives `irq_o` when any `per_en_i` bit is 1.
- R11: `irq_o` is registered. It rises one clock after the flag that causes it. Flags of sources that do not belong to the current mode do not drive it, and those flags stay stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | Counting enabled |
| mode_cnt_i | input | 1 | 0 = calendar mode, 1 = counter mode |
| per_en_i | input | 8 | Periodic source enables |
| per_evt_i | input | 8 | Periodic event strobes |
| alm_irq_en_i | input | 1 | Alarm request enable |
| ovf_irq_en_i | input | 1 | Overflow request enable |
| cmp_irq_en_i | input | 1 | Compare request enable |
| cur_min_i | input | 6 | Running minute |
| cur_hr_i | input | 5 | Running hour |
| cur_wday_i | input | 3 | Running weekday |
| alm_min_i | input | 6 | Alarm minute |
| alm_hr_i | input | 5 | Alarm hour |
| alm_wday_i | input | 3 | Alarm weekday |
| alm_fld_en_i | input | 3 | Alarm field selects |
| ovf_i | input | 1 | Counter overflow strobe |
| cmp_i | input | 1 | Counter compare-match strobe |
| flag_clr_i | input | 4 | Per-flag clear pulses |
| per_flag_o | output | 1 | Periodic flag |
| alm_flag_o | output | 1 | Alarm flag |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_flag_o | output | 1 | Compare flag |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Two functions can fall in the same cycle: a software clear and a fresh event on the same flag. The bench first sets the periodic flag. It then drives a clear pulse and a new enabled periodic strobe in the same cycle, and expects the flag to read 1 afterwards. A clear pulse alone must then bring the flag to 0. The bench also drives an overflow strobe in calendar mode together with a periodic strobe, and expects only the periodic flag to rise.

// File: rtl/cti_pkg.sv
// Shared constants for the calendar timer interrupt controller.
// Assumes four flag sources, indexed as below, in every module.
package cti_pkg;
    localparam int NUM_PER = 8;   // periodic sources
    localparam int NUM_SRC = 4;   // flag sources
    localparam int NUM_FLD = 3;   // alarm fields
    localparam int SRC_PER = 0;
    localparam int SRC_ALM = 1;
    localparam int SRC_OVF = 2;
    localparam int SRC_CMP = 3;
    localparam int FLD_MIN = 0;
    localparam int FLD_HR  = 1;
    localparam int FLD_WD  = 2;
endpackage

// File: rtl/cti_periodic.sv
// Merges the periodic strobes into one hit pulse.
// Assumes the strobes are single-cycle and already synchronous to clk.
module cti_periodic #(
    parameter int NUM = cti_pkg::NUM_PER
) (
    input  logic [NUM-1:0] en_i,
    input  logic [NUM-1:0] evt_i,
    input  logic           active_i,
    output logic           hit_o
);
    logic [NUM-1:0] gated;

    // Gate each strobe with its own enable bit.
    for (genvar k = 0; k < NUM; k++) begin : g_gate
        assign gated[k] = evt_i[k] & en_i[k];
    end

    // Any gated strobe produces a hit, but only while the mode and run allow it.
    always_comb begin
        hit_o = active_i & (|gated);
    end
endmodule

// File: rtl/cti_alarm_cmp.sv
// Partial-field alarm comparator with edge detection.
// Assumes the time inputs are stable between counter updates.
// The event fires when the selected fields move into a match.
module cti_alarm_cmp #(
    parameter int MIN_W = 6,
    parameter int HR_W  = 5,
    parameter int WD_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [MIN_W-1:0] cur_min_i,
    input  logic [HR_W-1:0]  cur_hr_i,
    input  logic [WD_W-1:0]  cur_wday_i,
    input  logic [MIN_W-1:0] alm_min_i,
    input  logic [HR_W-1:0]  alm_hr_i,
    input  logic [WD_W-1:0]  alm_wday_i,
    input  logic [cti_pkg::NUM_FLD-1:0] fld_en_i,
    output logic             match_o,
    output logic             rise_o
);
    import cti_pkg::*;

    logic [NUM_FLD-1:0] fld_eq;
    logic               match_q;

    // Compare each field separately.
    always_comb begin
        fld_eq[FLD_MIN] = (cur_min_i == alm_min_i);
        fld_eq[FLD_HR]  = (cur_hr_i == alm_hr_i);
        fld_eq[FLD_WD]  = (cur_wday_i == alm_wday_i);
    end

    // Unselected fields count as equal; with no field selected there is no match.
    always_comb begin
        match_o = (&(fld_eq | ~fld_en_i)) & (|fld_en_i);
        rise_o  = match_o & ~match_q;
    end

    // Remember the previous match state for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match_o;
    end

    p_no_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fld_en_i == '0) |-> !match_o);
endmodule

// File: rtl/cti_flag_bank.sv
// Sticky flags: set by events, cleared by pulses; set wins over clear.
// Assumes the event and clear inputs are single-cycle pulses.
module cti_flag_bank #(
    parameter int N = cti_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flag_o
);
    for (genvar k = 0; k < N; k++) begin : g_flag
        logic f_q;

        // Hold the flag until it is cleared, giving priority to a new event.
        always_ff @(posedge clk) begin
            if (!rst_n)        f_q <= 1'b0;
            else if (set_i[k]) f_q <= 1'b1;
            else if (clr_i[k]) f_q <= 1'b0;
        end
        assign flag_o[k] = f_q;

        p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[k] |=> flag_o[k]);
        p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i[k] && !set_i[k]) |=> !flag_o[k]);
    end
endmodule

// File: rtl/cti_irq_gen.sv
// Registered request: OR of flags that are enabled and active in the mode.
// Assumes the enable and mode-active vectors use the flag indexing.
module cti_irq_gen #(
    parameter int N = cti_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] en_i,
    input  logic [N-1:0] act_i,
    output logic         irq_o
);
    logic req_d;

    // Combine the qualified flags.
    always_comb begin
        req_d = |(flag_i & en_i & act_i);
    end

    // Register the request, adding one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= req_d;
    end

    p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_i == '0) |=> !irq_o);
endmodule

// File: rtl/caltmr_irq_ctrl.sv
// Top of the calendar timer interrupt controller. Qualifies each event with
// run and mode, stores it in sticky flags and forms the registered request.
// Assumes that configuration is changed only while run_i is 0.
module caltmr_irq_ctrl #(
    parameter int MIN_W = 6,
    parameter int HR_W  = 5,
    parameter int WD_W  = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         run_i,
    input  logic                         mode_cnt_i,
    input  logic [cti_pkg::NUM_PER-1:0]  per_en_i,
    input  logic [cti_pkg::NUM_PER-1:0]  per_evt_i,
    input  logic                         alm_irq_en_i,
    input  logic                         ovf_irq_en_i,
    input  logic                         cmp_irq_en_i,
    input  logic [MIN_W-1:0]             cur_min_i,
    input  logic [HR_W-1:0]              cur_hr_i,
    input  logic [WD_W-1:0]              cur_wday_i,
    input  logic [MIN_W-1:0]             alm_min_i,
    input  logic [HR_W-1:0]              alm_hr_i,
    input  logic [WD_W-1:0]              alm_wday_i,
    input  logic [cti_pkg::NUM_FLD-1:0]  alm_fld_en_i,
    input  logic                         ovf_i,
    input  logic                         cmp_i,
    input  logic [cti_pkg::NUM_SRC-1:0]  flag_clr_i,
    output logic                         per_flag_o,
    output logic                         alm_flag_o,
    output logic                         ovf_flag_o,
    output logic                         cmp_flag_o,
    output logic                         irq_o
);
    import cti_pkg::*;

    logic               cal_act;
    logic               cnt_act;
    logic               per_hit;
    logic               alm_match;
    logic               alm_rise;
    logic [NUM_SRC-1:0] evt;
    logic [NUM_SRC-1:0] flags;
    logic [NUM_SRC-1:0] req_en;
    logic [NUM_SRC-1:0] src_act;

    // Work out which mode is allowed to produce events.
    always_comb begin
        cal_act = run_i & ~mode_cnt_i;
        cnt_act = run_i & mode_cnt_i;
    end

    cti_periodic #(.NUM(NUM_PER)) per_i (
        .en_i    (per_en_i),
        .evt_i   (per_evt_i),
        .active_i(cal_act),
        .hit_o   (per_hit)
    );

    cti_alarm_cmp #(.MIN_W(MIN_W), .HR_W(HR_W), .WD_W(WD_W)) alm_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_min_i (cur_min_i),
        .cur_hr_i  (cur_hr_i),
        .cur_wday_i(cur_wday_i),
        .alm_min_i (alm_min_i),
        .alm_hr_i  (alm_hr_i),
        .alm_wday_i(alm_wday_i),
        .fld_en_i  (alm_fld_en_i),
        .match_o   (alm_match),
        .rise_o    (alm_rise)
    );

    // Collect the qualified events, plus the request enables and mode masks.
    always_comb begin
        evt[SRC_PER]     = per_hit;
        evt[SRC_ALM]     = alm_rise & cal_act;
        evt[SRC_OVF]     = ovf_i & cnt_act;
        evt[SRC_CMP]     = cmp_i & cnt_act;
        req_en[SRC_PER]  = |per_en_i;
        req_en[SRC_ALM]  = alm_irq_en_i;
        req_en[SRC_OVF]  = ovf_irq_en_i;
        req_en[SRC_CMP]  = cmp_irq_en_i;
        src_act[SRC_PER] = ~mode_cnt_i;
        src_act[SRC_ALM] = ~mode_cnt_i;
        src_act[SRC_OVF] = mode_cnt_i;
        src_act[SRC_CMP] = mode_cnt_i;
    end

    cti_flag_bank #(.N(NUM_SRC)) flg_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (evt),
        .clr_i (flag_clr_i),
        .flag_o(flags)
    );

    cti_irq_gen #(.N(NUM_SRC)) irq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .flag_i(flags),
        .en_i  (req_en),
        .act_i (src_act),
        .irq_o (irq_o)
    );

    // Drive the flag outputs.
    always_comb begin
        per_flag_o = flags[SRC_PER];
        alm_flag_o = flags[SRC_ALM];
        ovf_flag_o = flags[SRC_OVF];
        cmp_flag_o = flags[SRC_CMP];
    end

    p_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> ((flags & ~$past(flags)) == '0));
    p_ovf_cal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_cnt_i && !ovf_flag_o) |=> !ovf_flag_o);
    p_cmp_cal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_cnt_i && !cmp_flag_o) |=> !cmp_flag_o);
    p_per_cnt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_cnt_i && !per_flag_o) |=> !per_flag_o);
    p_alm_fld_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_match && !alm_flag_o) |=> !alm_flag_o);
endmodule

// File: tb/caltmr_irq_ctrl_tb_top.sv
module caltmr_irq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       run_i, mode_cnt_i;
    logic [7:0] per_en_i, per_evt_i;
    logic       alm_irq_en_i, ovf_irq_en_i, cmp_irq_en_i;
    logic [5:0] cur_min_i, alm_min_i;
    logic [4:0] cur_hr_i, alm_hr_i;
    logic [2:0] cur_wday_i, alm_wday_i, alm_fld_en_i;
    logic       ovf_i, cmp_i;
    logic [3:0] flag_clr_i;
    logic       per_flag_o, alm_flag_o, ovf_flag_o, cmp_flag_o, irq_o;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    caltmr_irq_ctrl dut_i (.*);

    typedef struct packed {
        logic [3:0] req;
        logic       mode;
        logic [7:0] en;
        logic [7:0] evt;
        logic [2:0] fld;
        logic [5:0] mn;
        logic [4:0] hr;
        logic [2:0] wd;
        logic       ovf;
        logic       cmp;
        logic [3:0] exp;   // {cmp, ovf, alm, per}
    } vec_t;

    // Alarm registers are held at 30 min, 12 h, weekday 3.
    localparam vec_t VT [12] = '{
        '{4'd2, 1'b0, 8'h01, 8'h01, 3'b000, 6'd0,  5'd0,  3'd0, 1'b0, 1'b0, 4'b0001}, // R2 quarter
        '{4'd2, 1'b0, 8'h80, 8'h80, 3'b000, 6'd0,  5'd0,  3'd0, 1'b0, 1'b0, 4'b0001}, // R2 year
        '{4'd3, 1'b0, 8'h0F, 8'hF0, 3'b000, 6'd0,  5'd0,  3'd0, 1'b0, 1'b0, 4'b0000}, // R3 disabled
        '{4'd4, 1'b0, 8'h00, 8'h00, 3'b001, 6'd30, 5'd0,  3'd0, 1'b0, 1'b0, 4'b0010}, // R4 minute only
        '{4'd4, 1'b0, 8'h00, 8'h00, 3'b011, 6'd30, 5'd5,  3'd0, 1'b0, 1'b0, 4'b0000}, // R4 hour differs
        '{4'd4, 1'b0, 8'h00, 8'h00, 3'b111, 6'd30, 5'd12, 3'd3, 1'b0, 1'b0, 4'b0010}, // R4 all fields
        '{4'd5, 1'b0, 8'h00, 8'h00, 3'b000, 6'd30, 5'd12, 3'd3, 1'b0, 1'b0, 4'b0000}, // R5 none selected
        '{4'd6, 1'b1, 8'h00, 8'h00, 3'b000, 6'd0,  5'd0,  3'd0, 1'b1, 1'b0, 4'b0100}, // R6 overflow
        '{4'd6, 1'b1, 8'h00, 8'h00, 3'b000, 6'd0,  5'd0,  3'd0, 1'b0, 1'b1, 4'b1000}, // R6 compare
        '{4'd7, 1'b1, 8'hFF, 8'hFF, 3'b111, 6'd30, 5'd12, 3'd3, 1'b0, 1'b0, 4'b0000}, // R7 calendar in counter
        '{4'd7, 1'b0, 8'h00, 8'h00, 3'b000, 6'd0,  5'd0,  3'd0, 1'b1, 1'b1, 4'b0000}, // R7 counter in calendar
        '{4'd7, 1'b0, 8'h04, 8'h04, 3'b000, 6'd0,  5'd0,  3'd0, 1'b1, 1'b0, 4'b0001}  // R7 mixed
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] flags();
        return {cmp_flag_o, ovf_flag_o, alm_flag_o, per_flag_o};
    endfunction

    task automatic idle();
        per_evt_i  = '0;
        ovf_i      = 0;
        cmp_i      = 0;
        flag_clr_i = '0;
        cur_min_i  = '0;
        cur_hr_i   = '0;
        cur_wday_i = '0;
    endtask

    task automatic clear_all();
        flag_clr_i = 4'hF;
        tick();
        flag_clr_i = '0;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; run_i = 0; mode_cnt_i = 0; per_en_i = '0;
        alm_irq_en_i = 0; ovf_irq_en_i = 0; cmp_irq_en_i = 0;
        alm_min_i = 6'd30; alm_hr_i = 5'd12; alm_wday_i = 3'd3; alm_fld_en_i = '0;
        idle();
        @(negedge clk);
        tick(); tick();
        chk("R1 flags", {28'd0, flags()}, 32'd0);
        chk("R1 irq", {31'd0, irq_o}, 32'd0);
        rst_n = 1;
        run_i = 1;
        tick();

        // Vector table walk.
        foreach (VT[v]) begin
            mode_cnt_i   = VT[v].mode;
            per_en_i     = VT[v].en;
            alm_fld_en_i = VT[v].fld;
            tick();
            per_evt_i  = VT[v].evt;
            cur_min_i  = VT[v].mn;
            cur_hr_i   = VT[v].hr;
            cur_wday_i = VT[v].wd;
            ovf_i      = VT[v].ovf;
            cmp_i      = VT[v].cmp;
            tick();
            idle();
            n_chk++;
            if (flags() !== VT[v].exp) begin
                n_bad++;
                $display("FAIL R%0d vector %0d: actual %b expected %b", VT[v].req, v, flags(), VT[v].exp);
            end
            clear_all();
        end

        // R8: nothing while stopped.
        run_i = 0; mode_cnt_i = 0; per_en_i = 8'hFF; alm_fld_en_i = 3'b111;
        tick();
        per_evt_i = 8'hFF; cur_min_i = 6'd30; cur_hr_i = 5'd12; cur_wday_i = 3'd3;
        tick();
        idle();
        mode_cnt_i = 1; ovf_i = 1; cmp_i = 1;
        tick();
        idle();
        chk("R8 stopped", {28'd0, flags()}, 32'd0);
        run_i = 1; mode_cnt_i = 0; alm_fld_en_i = '0;
        tick();

        // R9: set beats clear in the same cycle.
        per_en_i = 8'h08; per_evt_i = 8'h08;
        tick();
        per_evt_i = 8'h08; flag_clr_i = 4'b0001;
        tick();
        idle();
        chk("R9 set wins", {31'd0, per_flag_o}, 32'd1);
        flag_clr_i = 4'b0001;
        tick();
        flag_clr_i = '0;
        chk("R9 clear", {31'd0, per_flag_o}, 32'd0);
        per_en_i = '0;
        tick();

        // R10: alarm flag requests only when enabled.
        alm_fld_en_i = 3'b001;
        tick();
        cur_min_i = 6'd30;
        tick();
        idle();
        chk("R10 alarm flag", {31'd0, alm_flag_o}, 32'd1);
        tick();
        chk("R10 no request", {31'd0, irq_o}, 32'd0);
        alm_irq_en_i = 1;
        tick();
        chk("R10 request", {31'd0, irq_o}, 32'd1);
        alm_irq_en_i = 0; alm_fld_en_i = '0;
        clear_all();

        // R11: one-cycle latency and mode masking of the request.
        mode_cnt_i = 1; ovf_irq_en_i = 1;
        tick();
        ovf_i = 1;
        tick();
        idle();
        chk("R11 flag first", {30'd0, ovf_flag_o, irq_o}, 32'b10);
        tick();
        chk("R11 irq next", {31'd0, irq_o}, 32'd1);
        mode_cnt_i = 0;
        tick();
        chk("R11 masked", {30'd0, ovf_flag_o, irq_o}, 32'b10);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule